// File: doc/BRIEF.md
# Programmable System Clock Divider

This block slows a master clock for the CPU and its peripherals by an integer factor from 1 to 129. It does not produce a new clock net. It produces a one-cycle clock-enable pulse, `ce_o`, that fires once per divided period. It also produces a phase level, `phase_o`, with the shape the divided clock would have. Downstream logic stays on the master clock and qualifies its updates with `ce_o`.

A byte-wide control register sets the division:

- **Bit 7** turns division on.
- **Bits 6..0** hold a code `d`. The divisor is `N = 129 - d`.

The register guards itself against accidental retuning:

- A code is accepted only in the same write that sets the enable, and only while division is off.
- While division is on, the only write that has any effect is one that clears bit 7.

A new setting never cuts a period short. It is picked up at the next divided-period boundary. In undivided operation every cycle is a boundary.

Top module: `sysclk_divider`

## Requirements
- R1: After reset the register reads 0x00, `ce_o` is high in every cycle and `phase_o` is high.
- R2: `rd_data` always shows the register: bit 7 is the enable, bits 6..0 are the code.
- R3: While the enable is 0, a write with bit 7 = 1 sets the enable and loads bits 6..0 as the code in the same cycle.
- R4: While the enable is 0, a write with bit 7 = 0 changes nothing; the written code bits are discarded.
- R5: While the enable is 1, a write with bit 7 = 1 is ignored entirely.
- R6: While the enable is 1, a write with bit 7 = 0 clears the enable and keeps the stored code.
- R7: In divided operation with divisor `N = 129 - code`, `ce_o` is high for exactly one cycle in every `N` cycles.
- R8: In divided operation, `phase_o` is high for the first floor(N/2) cycles of each period and low for the remaining cycles. The `ce_o` cycle is the last low cycle.
- R9: A change of enable or code takes effect only at the end of the current period. A clear written in the middle of a period lets that period finish at the old length.
- R10: In undivided operation (N = 1), `ce_o` is high every cycle and `phase_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit 7 is the enable, bits 6..0 are the code |
| rd_data | output | 8 | Register readback |
| ce_o | output | 1 | Clock-enable pulse, high in the last cycle of each divided period |
| phase_o | output | 1 | Divided-clock phase level |

## Verification
Two events can fall in the same cycle: a register write and a period boundary. At that boundary the divisor for the next period is latched from the register as it was before the write. The write therefore only becomes visible one whole period later. In undivided operation every cycle is a boundary, so each write to the enable lands on one. Directed cases also write exactly in the cycle where `ce_o` is high. The bench judges every cycle against a reference model that applies this ordering, comparing `ce_o`, `phase_o` and `rd_data`.

// File: rtl/sysclk_divider.sv
module sysclk_divider #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W:0]   wr_data,
  output logic [CODE_W:0]   rd_data,
  output logic              ce_o,
  output logic              phase_o
);
  localparam int CNT_W   = CODE_W + 1;
  localparam int DIV_TOP = (1 << CODE_W) + 1;

  logic              en_r;
  logic [CODE_W-1:0] code_r;
  logic [CNT_W-1:0]  cnt_r;
  logic [CNT_W-1:0]  act_n_r;
  logic [CNT_W-1:0]  next_n;

  assign rd_data = {en_r, code_r};
  assign next_n  = en_r ? (CNT_W'(DIV_TOP) - CNT_W'(code_r)) : CNT_W'(1);
  assign ce_o    = (cnt_r == act_n_r - CNT_W'(1));
  assign phase_o = (act_n_r == CNT_W'(1)) || (cnt_r < (act_n_r >> 1));

  // Register: code loads only with a rising enable; while on, only a clear is heard
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r   <= 1'b0;
      code_r <= '0;
    end else if (wr_en) begin
      if (!en_r && wr_data[CODE_W]) begin
        en_r   <= 1'b1;
        code_r <= wr_data[CODE_W-1:0];
      end else if (en_r && !wr_data[CODE_W]) begin
        en_r <= 1'b0;
      end
    end
  end

  // Period counter; the divisor is re-sampled only at a boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_r   <= '0;
      act_n_r <= CNT_W'(1);
    end else if (ce_o) begin
      cnt_r   <= '0;
      act_n_r <= next_n;
    end else begin
      cnt_r <= cnt_r + CNT_W'(1);
    end
  end

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[CODE_W] && wr_data[CODE_W]) |=> (rd_data == $past(wr_data)));

  a_r4_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[CODE_W] && !wr_data[CODE_W]) |=> $stable(rd_data));

  a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[CODE_W] && wr_data[CODE_W]) |=> $stable(rd_data));

  a_r6_clear_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[CODE_W] && !wr_data[CODE_W]) |=>
      (!rd_data[CODE_W] && rd_data[CODE_W-1:0] == $past(rd_data[CODE_W-1:0])));

  a_r9_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_o |=> $stable(act_n_r));

  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_r < act_n_r);

  a_r10_bypass_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (act_n_r == CNT_W'(1)) |-> (ce_o && phase_o));
endmodule

// File: tb/sysclk_divider_bench.sv
module sysclk_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ce_o;
  logic       phase_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  bit       m_en   = 1'b0;
  bit [6:0] m_code = 7'd0;
  int       m_n    = 1;
  int       m_cnt  = 0;

  always #4 clk = ~clk;

  sysclk_divider u_sysclk_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ce_o(ce_o), .phase_o(phase_o)
  );

  function automatic bit exp_ce();
    return m_cnt == m_n - 1;
  endfunction

  function automatic bit exp_phase();
    return (m_n == 1) || (m_cnt < m_n / 2);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit tick;
    tick = (m_cnt == m_n - 1);
    if (!rst_n) begin
      m_en = 0; m_code = 0; m_n = 1; m_cnt = 0;
    end else begin
      if (tick) begin
        m_cnt = 0;
        m_n   = m_en ? 129 - int'(m_code) : 1;
      end else begin
        m_cnt++;
      end
      if (wr_en) begin
        if (!m_en && wr_data[7]) begin m_en = 1; m_code = wr_data[6:0]; end
        else if (m_en && !wr_data[7]) m_en = 0;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 rd_data", rd_data, {m_en, m_code});
    check("R7 ce_o", ce_o, exp_ce());
    check("R8 phase_o", phase_o, exp_phase());
  endtask

  task automatic write(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    step();
  endtask

  task automatic wait_ce();
    for (int i = 0; i < 200 && !ce_o; i++) step();
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset ce_o", ce_o, 1);
    check("R1 reset phase_o", phase_o, 1);

    // R4: code with enable low is discarded
    write(8'h35);
    check("R4 discard", rd_data, 8'h00);
    for (int i = 0; i < 3; i++) step();
    check("R10 undivided ce", ce_o, 1);

    // R3: load N=2 (code 127)
    write(8'hFF);
    check("R3 load", rd_data, 8'hFF);
    for (int i = 0; i < 8; i++) step();

    // R5: locked write ignored
    write(8'h81);
    check("R5 locked", rd_data, 8'hFF);

    // R6: clear keeps code
    write(8'h00);
    check("R6 clear", rd_data, 8'h7F);
    for (int i = 0; i < 6; i++) step();

    // R8: odd divisor N=3 (code 126), then N=129 (code 0)
    write(8'hFE);
    for (int i = 0; i < 12; i++) step();
    write(8'h00);
    wait_ce(); step();
    write(8'h80);
    for (int i = 0; i < 300; i++) step();

    // R9: N=10 (code 119), clear mid-period
    write(8'h00);
    wait_ce(); step();
    write(8'hF7);
    wait_ce(); step();
    wait_ce();
    step(); step(); step();
    write(8'h00);
    k = 0;
    for (int i = 1; i < 40; i++) begin
      step();
      if (ce_o) begin k = i; break; end
    end
    check("R9 old period finishes", k, 6);
    step();
    check("R10 bypass after clear", ce_o, 1);
    check("R10 bypass phase", phase_o, 1);

    // write in the same cycle as a boundary
    write(8'hFA);
    wait_ce();
    wr_en = 1'b1; wr_data = 8'h00;
    step();

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        logic [7:0] v;
        v[7]   = $urandom_range(0, 1);
        v[6:0] = ($urandom_range(0, 7) == 0) ? 7'($urandom_range(0, 127))
                                             : 7'($urandom_range(110, 127));
        write(v);
      end else begin
        step();
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule